// File: doc/BRIEF.md
# Interrupt Acceptance Sequencer

This block sits beside the control unit of an 8-bit processor core. At every instruction boundary it decides whether an interrupt is taken and, if so, walks through the bus steps of that entry: saving the program counter, running the acknowledge cycle, and delivering a new program counter or an injected instruction byte. It holds the two interrupt-enable flags, a primary flag that gates maskable requests and a shadow flag that keeps the primary's value across a non-maskable entry.

A non-maskable request is a falling edge on `nmi_n`. It is latched at once and served at the next boundary. It takes priority over a maskable request, and its entry saves the PC and jumps to a fixed address. A maskable request (`int_n` low while the primary flag is set) opens an acknowledge cycle in which `m1_n` and `iorq_n` are low together. What follows depends on the stored interrupt mode. Mode 0 hands the data-bus byte to the core as an instruction with no PC save. Mode 1 ignores the bus, saves the PC and jumps to a fixed address. Mode 2 saves the PC first, then forms a table address from the page input and the bus byte, reads a 16-bit word there and jumps to it. Stack writes, stack reads and the table read leave the block as request/done handshakes.

The sequencer has eight states. `ST_IDLE` waits for a boundary. `ST_NMI_PUSH` saves the PC for a non-maskable entry. `ST_IM2_PUSH` saves the PC before a mode 2 acknowledge. `ST_ACK` drives the acknowledge pair. `ST_IM1_PUSH` saves the PC after a mode 1 acknowledge. `ST_VEC_RD` reads the mode 2 table word. `ST_INJECT` hands over the mode 0 byte. `ST_LOAD` presents the new PC.

The transitions are:
- IDLE→NMI_PUSH: boundary with a non-maskable request pending.
- IDLE→IM2_PUSH: maskable request accepted in mode 2.
- IDLE→ACK: maskable request accepted in mode 0 or 1.
- NMI_PUSH→LOAD and IM1_PUSH→LOAD: on `push_done`.
- IM2_PUSH→ACK: on `push_done`.
- ACK→INJECT, ACK→IM1_PUSH and ACK→VEC_RD: on the last acknowledge cycle, chosen by mode.
- VEC_RD→LOAD: on `vec_rd_done`.
- INJECT→IDLE and LOAD→IDLE: unconditional.

Top module: `irq_seq`

## Requirements
- R1: A falling edge on `nmi_n` sets a one-bit pending flag. The flag is cleared when the non-maskable entry starts, so each edge yields exactly one entry, and a later boundary with no new edge takes nothing.
- R2: A non-maskable entry copies the primary enable flag into the shadow flag and clears the primary. It then requests one PC push and presents `pc_load_val` = 0x0066 for one cycle. `m1_n` and `iorq_n` stay high throughout.
- R3: A `retn_req` pulse copies the shadow flag into the primary flag and raises `pop_req` for one cycle, one clock later.
- R4: A maskable request is taken only at a boundary (`insn_end` high in `ST_IDLE`) with `int_n` low and the primary flag set. Taking it clears both flags. With the primary flag clear, a low `int_n` causes no acknowledge, no push and no PC load.
- R5: When a non-maskable request is pending at a boundary where a maskable request is also present, the non-maskable entry is taken. The maskable request is served later only if `int_n` is still low once the primary flag is set again.
- R6: During acknowledge, `m1_n` and `iorq_n` are low together for exactly ACK_CYCLES cycles and then both return high. `iorq_n` is never low without `m1_n`.
- R7: In mode 1 the sequence is acknowledge, then one PC push, then `pc_load_val` = 0x0038. The data-bus byte has no effect.
- R8: In mode 2 the PC push comes before the acknowledge. The byte on `data_in` in the last acknowledge cycle forms `vec_addr` = {`i_page`, byte}. The word returned on `vec_rd_data` becomes `pc_load_val`.
- R9: In mode 0 the acknowledge is followed by one cycle of `inject_valid` carrying the byte sampled in the last acknowledge cycle. There is no push and no PC load.
- R10: An `im_wr` pulse stores `im_val` as the mode when the value is 0, 1 or 2. The value 3 leaves the mode unchanged. Reset selects mode 0, clears both flags and leaves all requests low with `m1_n` and `iorq_n` high.
- R11: `ei_req` sets both flags and `di_req` clears both. An acceptance in the same cycle overrides either.
- R12: At most one of `push_req`, `vec_rd_req`, `pc_load_valid` and `inject_valid` is high in any cycle. A push or table-read request stays high until its done input is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nmi_n | input | 1 | Non-maskable request, falling-edge sensitive |
| int_n | input | 1 | Maskable request, active low level |
| insn_end | input | 1 | Instruction boundary strobe |
| im_wr | input | 1 | Mode write strobe |
| im_val | input | 2 | Mode value for `im_wr` |
| ei_req | input | 1 | Enable both flags |
| di_req | input | 1 | Disable both flags |
| retn_req | input | 1 | Return from non-maskable service |
| i_page | input | 8 | Page register, high byte of the mode 2 table address |
| data_in | input | 8 | Data-bus byte supplied during acknowledge |
| push_done | input | 1 | Stack push finished |
| vec_rd_done | input | 1 | Table read finished |
| vec_rd_data | input | 16 | Word returned by the table read |
| m1_n | output | 1 | Acknowledge, fetch-cycle marker, active low |
| iorq_n | output | 1 | Acknowledge, I/O marker, active low |
| iff1 | output | 1 | Primary enable flag |
| iff2 | output | 1 | Shadow enable flag |
| push_req | output | 1 | Request to push the PC |
| vec_rd_req | output | 1 | Request to read the table word |
| vec_addr | output | 16 | Table address for the read |
| pc_load_valid | output | 1 | New PC valid, one cycle |
| pc_load_val | output | 16 | New PC value |
| inject_valid | output | 1 | Injected instruction byte valid, one cycle |
| inject_byte | output | 8 | Injected instruction byte |
| pop_req | output | 1 | Request to pop the PC |

## Verification
Each result has a fixed delay after its stimulus:
- The pending flag is set on the first edge after the fall on `nmi_n`.
- The first entry state is reached on the edge that samples `insn_end`.
- `pop_req` and the flag updates appear one edge after their strobe.
- The acknowledge lasts ACK_CYCLES cycles. With the bench's zero-wait handshakes, the longest entry (mode 2) finishes five cycles after the boundary.

The bench drives inputs 1 ns after the falling clock edge. A monitor counts events and stamps their cycle on every falling edge. Each boundary is judged from counter differences over a ten-cycle window, which contains any whole entry, and the push-versus-acknowledge order is judged from the cycle stamps.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NMI_PUSH,
        ST_IM2_PUSH,
        ST_ACK,
        ST_IM1_PUSH,
        ST_VEC_RD,
        ST_INJECT,
        ST_LOAD
    } seq_state_e;

    localparam logic [1:0] MODE_INJECT = 2'd0;
    localparam logic [1:0] MODE_FIXED  = 2'd1;
    localparam logic [1:0] MODE_TABLE  = 2'd2;
    localparam logic [1:0] MODE_BAD    = 2'd3;

endpackage

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n,
    input  logic take_nmi,
    output logic nmi_pend
);

    logic nmi_last_q;
    logic nmi_fall;
    logic pend_d;

    assign nmi_fall = nmi_last_q & ~nmi_n;

    always_comb begin
        pend_d = nmi_pend;
        if (take_nmi) begin
            pend_d = 1'b0;
        end
        if (nmi_fall) begin
            pend_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_last_q <= 1'b1;
            nmi_pend   <= 1'b0;
        end else begin
            nmi_last_q <= nmi_n;
            nmi_pend   <= pend_d;
        end
    end

    AST_NMI_ONE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) // R1
        (take_nmi && nmi_n) |=> !nmi_pend);

    AST_NMI_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n) // R1
        (nmi_pend && !take_nmi) |=> nmi_pend);

    AST_NMI_TAKE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n) // R1
        take_nmi |-> nmi_pend);

endmodule

// File: rtl/irq_iff.sv
module irq_iff (
    input  logic clk,
    input  logic rst_n,
    input  logic take_nmi,
    input  logic take_int,
    input  logic ei_req,
    input  logic di_req,
    input  logic retn_req,
    output logic iff1,
    output logic iff2,
    output logic pop_req
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iff1    <= 1'b0;
            iff2    <= 1'b0;
            pop_req <= 1'b0;
        end else begin
            pop_req <= retn_req;
            if (take_nmi) begin
                iff2 <= iff1;
                iff1 <= 1'b0;
            end else if (take_int || di_req) begin
                iff1 <= 1'b0;
                iff2 <= 1'b0;
            end else if (ei_req) begin
                iff1 <= 1'b1;
                iff2 <= 1'b1;
            end else if (retn_req) begin
                iff1 <= iff2;
            end
        end
    end

    AST_IFF_NMI_COPY: assert property (@(posedge clk) disable iff (!rst_n) // R2
        take_nmi |=> (!iff1 && (iff2 == $past(iff1))));

    AST_IFF_INT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) // R4
        take_int |=> (!iff1 && !iff2));

    AST_IFF_RETN_RESTORE: assert property (@(posedge clk) disable iff (!rst_n) // R3
        (retn_req && !take_nmi && !take_int && !di_req && !ei_req) |=> (pop_req && (iff1 == $past(iff2))));

    AST_IFF_EI_SET: assert property (@(posedge clk) disable iff (!rst_n) // R11
        (ei_req && !take_nmi && !take_int && !di_req) |=> (iff1 && iff2));

    AST_IFF_NO_TAKE_BOTH: assert property (@(posedge clk) disable iff (!rst_n) // R5
        !(take_nmi && take_int));

endmodule

// File: rtl/irq_ack_timer.sv
module irq_ack_timer #(
    parameter int ACK_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_ack,
    output logic ack_last
);

    localparam int CW = (ACK_CYCLES < 2) ? 1 : $clog2(ACK_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(ACK_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    assign ack_last = in_ack && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!in_ack || ack_last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_ACK_EXIT: assert property (@(posedge clk) disable iff (!rst_n) // R6
        ack_last |=> !in_ack);

    AST_ACK_STAY: assert property (@(posedge clk) disable iff (!rst_n) // R6
        (in_ack && !ack_last) |=> in_ack);

endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_seq_pkg::*;
#(
    parameter int DATA_W              = 8,
    parameter int ACK_CYCLES          = 2,
    parameter logic [15:0] NMI_TARGET = 16'h0066,
    parameter logic [15:0] IM1_TARGET = 16'h0038
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_n,
    input  logic              int_n,
    input  logic              insn_end,
    input  logic              im_wr,
    input  logic [1:0]        im_val,
    input  logic              ei_req,
    input  logic              di_req,
    input  logic              retn_req,
    input  logic [DATA_W-1:0] i_page,
    input  logic [DATA_W-1:0] data_in,
    input  logic              push_done,
    input  logic              vec_rd_done,
    input  logic [2*DATA_W-1:0] vec_rd_data,
    output logic              m1_n,
    output logic              iorq_n,
    output logic              iff1,
    output logic              iff2,
    output logic              push_req,
    output logic              vec_rd_req,
    output logic [2*DATA_W-1:0] vec_addr,
    output logic              pc_load_valid,
    output logic [2*DATA_W-1:0] pc_load_val,
    output logic              inject_valid,
    output logic [DATA_W-1:0] inject_byte,
    output logic              pop_req
);

    localparam int ADDR_W = 2 * DATA_W;

    seq_state_e          state_q, state_d;
    logic [1:0]          im_q;
    logic [1:0]          mode_q, mode_d;
    logic [ADDR_W-1:0]   tgt_q, tgt_d;
    logic [ADDR_W-1:0]   vaddr_q, vaddr_d;
    logic [DATA_W-1:0]   vbyte_q, vbyte_d;
    logic                nmi_pend;
    logic                take_nmi;
    logic                take_int;
    logic                in_ack;
    logic                ack_last;
    logic                at_boundary;

    assign at_boundary = (state_q == ST_IDLE) && insn_end;
    assign take_nmi    = at_boundary && nmi_pend;
    assign take_int    = at_boundary && !nmi_pend && !int_n && iff1;
    assign in_ack      = (state_q == ST_ACK);

    irq_nmi_edge u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_n    (nmi_n),
        .take_nmi (take_nmi),
        .nmi_pend (nmi_pend)
    );

    irq_iff u_iff (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_nmi (take_nmi),
        .take_int (take_int),
        .ei_req   (ei_req),
        .di_req   (di_req),
        .retn_req (retn_req),
        .iff1     (iff1),
        .iff2     (iff2),
        .pop_req  (pop_req)
    );

    irq_ack_timer #(
        .ACK_CYCLES (ACK_CYCLES)
    ) u_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_ack   (in_ack),
        .ack_last (ack_last)
    );

    // Mode register: the unused encoding is dropped
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            im_q <= MODE_INJECT;
        end else if (im_wr && (im_val != MODE_BAD)) begin
            im_q <= im_val;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        tgt_d   = tgt_q;
        vaddr_d = vaddr_q;
        vbyte_d = vbyte_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_nmi) begin
                    state_d = ST_NMI_PUSH;
                end else if (take_int) begin
                    mode_d  = im_q;
                    state_d = (im_q == MODE_TABLE) ? ST_IM2_PUSH : ST_ACK;
                end
            end
            ST_NMI_PUSH: begin
                if (push_done) begin
                    tgt_d   = NMI_TARGET;
                    state_d = ST_LOAD;
                end
            end
            ST_IM2_PUSH: begin
                if (push_done) begin
                    state_d = ST_ACK;
                end
            end
            ST_ACK: begin
                if (ack_last) begin
                    vbyte_d = data_in;
                    vaddr_d = {i_page, data_in};
                    unique case (mode_q)
                        MODE_FIXED: state_d = ST_IM1_PUSH;
                        MODE_TABLE: state_d = ST_VEC_RD;
                        default:    state_d = ST_INJECT;
                    endcase
                end
            end
            ST_IM1_PUSH: begin
                if (push_done) begin
                    tgt_d   = IM1_TARGET;
                    state_d = ST_LOAD;
                end
            end
            ST_VEC_RD: begin
                if (vec_rd_done) begin
                    tgt_d   = vec_rd_data;
                    state_d = ST_LOAD;
                end
            end
            ST_INJECT: state_d = ST_IDLE;
            ST_LOAD:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_INJECT;
            tgt_q   <= '0;
            vaddr_q <= '0;
            vbyte_q <= '0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            tgt_q   <= tgt_d;
            vaddr_q <= vaddr_d;
            vbyte_q <= vbyte_d;
        end
    end

    // Outputs
    always_comb begin
        m1_n          = 1'b1;
        iorq_n        = 1'b1;
        push_req      = 1'b0;
        vec_rd_req    = 1'b0;
        pc_load_valid = 1'b0;
        inject_valid  = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_NMI_PUSH: push_req = 1'b1;
            ST_IM2_PUSH: push_req = 1'b1;
            ST_ACK: begin
                m1_n   = 1'b0;
                iorq_n = 1'b0;
            end
            ST_IM1_PUSH: push_req      = 1'b1;
            ST_VEC_RD:   vec_rd_req    = 1'b1;
            ST_INJECT:   inject_valid  = 1'b1;
            ST_LOAD:     pc_load_valid = 1'b1;
            default:     ;
        endcase
    end

    assign pc_load_val = tgt_q;
    assign vec_addr    = vaddr_q;
    assign inject_byte = vbyte_q;

    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n) // R12
        $onehot0({push_req, vec_rd_req, pc_load_valid, inject_valid}));

    AST_PUSH_HELD: assert property (@(posedge clk) disable iff (!rst_n) // R12
        (push_req && !push_done) |=> push_req);

    AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n) // R12
        (vec_rd_req && !vec_rd_done) |=> vec_rd_req);

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) // R4
        ((state_q == ST_IDLE) && !nmi_pend && !iff1) |=> iorq_n);

    AST_NMI_TARGET: assert property (@(posedge clk) disable iff (!rst_n) // R2
        ((state_q == ST_NMI_PUSH) && push_done) |=> (pc_load_valid && (pc_load_val == NMI_TARGET)));

    AST_TABLE_PUSH_FIRST: assert property (@(posedge clk) disable iff (!rst_n) // R8
        ((state_q == ST_IM2_PUSH) && push_done) |=> (!m1_n && !iorq_n));

    AST_ACK_PAIR: assert property (@(posedge clk) disable iff (!rst_n) // R6
        !iorq_n |-> !m1_n);

endmodule

// File: tb/irq_seq_bench.sv
`timescale 1ns/1ps
module irq_seq_bench;

    localparam int ACKC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_n = 1'b1, int_n = 1'b1, insn_end = 1'b0;
    logic        im_wr = 1'b0, ei_req = 1'b0, di_req = 1'b0, retn_req = 1'b0;
    logic [1:0]  im_val = 2'd0;
    logic [7:0]  i_page = 8'h00, cur_byte = 8'h00, junk = 8'h00;
    logic [7:0]  data_in;
    logic        push_done, vec_rd_done;
    logic [15:0] vec_rd_data;
    logic        m1_n, iorq_n, iff1, iff2, push_req, vec_rd_req, pc_load_valid, inject_valid, pop_req;
    logic [15:0] vec_addr, pc_load_val;
    logic [7:0]  inject_byte;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    function automatic logic [15:0] memf(input logic [15:0] a);
        return {a[7:0] ^ 8'hA5, a[15:8] + 8'h11};
    endfunction

    assign push_done   = push_req;
    assign vec_rd_done = vec_rd_req;
    assign vec_rd_data = memf(vec_addr);
    assign data_in     = iorq_n ? junk : cur_byte;

    irq_seq u_irq_seq (
        .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .int_n(int_n), .insn_end(insn_end),
        .im_wr(im_wr), .im_val(im_val), .ei_req(ei_req), .di_req(di_req), .retn_req(retn_req),
        .i_page(i_page), .data_in(data_in), .push_done(push_done), .vec_rd_done(vec_rd_done),
        .vec_rd_data(vec_rd_data), .m1_n(m1_n), .iorq_n(iorq_n), .iff1(iff1), .iff2(iff2),
        .push_req(push_req), .vec_rd_req(vec_rd_req), .vec_addr(vec_addr),
        .pc_load_valid(pc_load_valid), .pc_load_val(pc_load_val), .inject_valid(inject_valid),
        .inject_byte(inject_byte), .pop_req(pop_req)
    );

    // Monitor: cumulative counts and cycle stamps
    int cyc = 0, n_push = 0, n_ack = 0, n_load = 0, n_inj = 0, n_vrd = 0, n_pop = 0, n_pair_bad = 0;
    int t_push = 0, t_ack_first = 0, t_ack_last = 0;
    logic [15:0] last_load = 0, last_vaddr = 0;
    logic [7:0]  last_inj = 0;
    logic        prev_ack = 0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (m1_n != iorq_n) n_pair_bad <= n_pair_bad + 1;
            if (!m1_n && !iorq_n) begin
                n_ack <= n_ack + 1;
                t_ack_last <= cyc;
                if (!prev_ack) t_ack_first <= cyc;
            end
            prev_ack <= !iorq_n;
            if (push_req) begin n_push <= n_push + 1; t_push <= cyc; end
            if (pc_load_valid) begin n_load <= n_load + 1; last_load <= pc_load_val; end
            if (inject_valid) begin n_inj <= n_inj + 1; last_inj <= inject_byte; end
            if (vec_rd_req) begin n_vrd <= n_vrd + 1; last_vaddr <= vec_addr; end
            if (pop_req) n_pop <= n_pop + 1;
        end
    end

    task automatic chk(input string tag, input bit ok, input int got, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic strobe(input int which);
        step();
        case (which)
            0: ei_req = 1;
            1: di_req = 1;
            default: retn_req = 1;
        endcase
        step();
        ei_req = 0; di_req = 0; retn_req = 0;
    endtask

    task automatic set_im(input logic [1:0] v);
        step(); im_wr = 1; im_val = v;
        step(); im_wr = 0;
    endtask

    task automatic pulse_nmi();
        step(); nmi_n = 0;
        step(); nmi_n = 1;
    endtask

    // kind: 0 nothing taken, 1 non-maskable entry, 2 maskable entry in mode m
    task automatic boundary(input int kind, input int m, input string tag);
        int s_push, s_ack, s_load, s_inj, s_vrd, s_bad;
        logic [15:0] va;
        step();
        s_push = n_push; s_ack = n_ack; s_load = n_load; s_inj = n_inj; s_vrd = n_vrd; s_bad = n_pair_bad;
        junk = 8'($urandom);
        insn_end = 1;
        step(); insn_end = 0;
        repeat (10) step();
        va = {i_page, cur_byte};
        chk({tag, " R6 pair"}, n_pair_bad == s_bad, n_pair_bad - s_bad, 0);
        if (kind == 0) begin
            chk({tag, " R4 no ack"}, n_ack == s_ack, n_ack - s_ack, 0);
            chk({tag, " R4 no push"}, n_push == s_push, n_push - s_push, 0);
            chk({tag, " R4 no load"}, n_load == s_load && n_inj == s_inj, n_load - s_load, 0);
        end else if (kind == 1) begin
            chk({tag, " R2 no ack"}, n_ack == s_ack, n_ack - s_ack, 0);
            chk({tag, " R2 push"}, n_push - s_push == 1, n_push - s_push, 1);
            chk({tag, " R2 load"}, n_load - s_load == 1 && last_load == 16'h0066, last_load, 16'h0066);
        end else begin
            chk({tag, " R6 ack len"}, n_ack - s_ack == ACKC, n_ack - s_ack, ACKC);
            if (m == 0) begin
                chk({tag, " R9 no push"}, n_push == s_push && n_load == s_load, n_push - s_push, 0);
                chk({tag, " R9 inject"}, n_inj - s_inj == 1 && last_inj == cur_byte, last_inj, cur_byte);
            end else if (m == 1) begin
                chk({tag, " R7 push after ack"}, n_push - s_push == 1 && t_push > t_ack_last, t_push, t_ack_last + 1);
                chk({tag, " R7 load"}, n_load - s_load == 1 && last_load == 16'h0038, last_load, 16'h0038);
            end else begin
                chk({tag, " R8 push before ack"}, n_push - s_push == 1 && t_push < t_ack_first, t_push, t_ack_first - 1);
                chk({tag, " R8 vaddr"}, n_vrd - s_vrd == 1 && last_vaddr == va, last_vaddr, va);
                chk({tag, " R8 load"}, n_load - s_load == 1 && last_load == memf(va), last_load, memf(va));
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R12 got=%0h exp=%0h", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int ps;
        void'($urandom(32'h1234ABCD));
        repeat (3) step();
        // R10: reset state
        chk("R10 reset iff", iff1 == 0 && iff2 == 0, {iff1, iff2}, 0);
        chk("R10 reset ack", m1_n && iorq_n, {m1_n, iorq_n}, 3);
        chk("R10 reset req", !push_req && !pc_load_valid && !inject_valid && !vec_rd_req && !pop_req, 1, 0);
        rst_n = 1;
        repeat (2) step();
        // R4: masked request ignored
        int_n = 0; cur_byte = 8'h3C;
        boundary(0, 0, "R4 masked");
        // R11 + R10: enable, reset mode is 0
        strobe(0);
        chk("R11 ei", iff1 && iff2, {iff1, iff2}, 3);
        boundary(2, 0, "R10 reset mode0");
        chk("R4 flags cleared", !iff1 && !iff2, {iff1, iff2}, 0);
        // R10: encoding 3 ignored
        set_im(2'd1); set_im(2'd3); strobe(0);
        cur_byte = 8'hE7;
        boundary(2, 1, "R10 mode3 ignored");
        strobe(0); strobe(1);
        chk("R11 di", !iff1 && !iff2, {iff1, iff2}, 0);
        int_n = 1;
        // R1: one entry per edge
        strobe(0);
        pulse_nmi();
        boundary(1, 0, "R1 first");
        chk("R2 iff copy", !iff1 && iff2, {iff1, iff2}, 1);
        boundary(0, 0, "R1 no repeat");
        ps = n_pop;
        strobe(2);
        chk("R3 restore", iff1 && iff2, {iff1, iff2}, 3);
        chk("R3 pop", n_pop - ps == 1, n_pop - ps, 1);
        // Random mix
        for (int it = 0; it < 60; it++) begin
            int m; bit ie, wn, wi;
            m = int'($urandom % 3);
            ie = 1'($urandom);
            wn = 1'($urandom);
            wi = 1'($urandom);
            set_im(2'(m));
            strobe(ie ? 0 : 1);
            i_page = 8'($urandom); cur_byte = 8'($urandom);
            if (wn) pulse_nmi();
            int_n = !wi;
            if (wn) begin
                boundary(1, m, "R5 nmi first");
                chk("R2 iff rand", !iff1 && iff2 == ie, {iff1, iff2}, {1'b0, ie});
                if (wi) boundary(0, m, "R5 int blocked");
                ps = n_pop;
                strobe(2);
                chk("R3 rand pop", n_pop - ps == 1 && iff1 == ie, {n_pop - ps, iff1}, {1, ie});
                if (wi && ie) boundary(2, m, "R5 int later");
            end else if (wi && ie) begin
                boundary(2, m, "R7 R8 R9 rand");
                chk("R4 rand clear", !iff1 && !iff2, {iff1, iff2}, 0);
            end else begin
                boundary(0, m, "R4 rand none");
                chk("R11 rand keep", iff1 == ie, iff1, ie);
            end
            int_n = 1;
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule